// File: doc/BRIEF.md
# Triggered acquisition shutter controller

This block produces the exposure window (the shutter) for a pixel detector readout interface. It runs on the system clock: 50 MHz by default, so one timer count is 20 ns. A host issues a start command together with a mode and an acquisition time. The controller then opens the shutter either straight away or on an external trigger edge. It closes the shutter either after the programmed number of clock cycles or on a later trigger edge.

The external trigger and the active-low veto input are asynchronous. Each passes through a two-flop synchronizer. Only a falling trigger edge is an event, both for starting and for stopping. While veto is low, any acquisition is abandoned and the controller requests a matrix clear. A synchronous abort input does the same for one cycle.

The block drives four handshake outputs:
- an active-low mirror of the shutter
- a busy flag that is high whenever a trigger edge would be ignored
- the clear request
- the elapsed exposure length, counted in system clocks, with a valid flag, captured whenever a trigger edge ends the window.

Top module: `shutter_ctrl`

## Requirements
- R1: `mode_i` is decoded as follows: bit 0 set means a trigger edge starts the window, and bit 1 set means a trigger edge stops it. Modes with bit 0 clear open the shutter on the first clock after the start command is sampled in idle. Modes with bit 0 set first wait, armed, for a trigger edge.
- R2: Only a high-to-low transition of `trig_i` is a trigger event. A rising edge, or a static level, neither opens nor closes the shutter.
- R3: In modes with bit 1 clear, the shutter stays high for exactly `acq_time_i` clock cycles, using the value latched at the start command.
- R4: In mode 2, the shutter opens on the clock after the start command and closes on the next falling trigger edge.
- R5: In mode 3, the falling edge that opened the shutter never closes it. Only a later, separate falling edge closes it.
- R6: When a trigger edge closes the window, `dur_o` receives the number of cycles the shutter was high and `dur_valid_o` rises. The count saturates at the all-ones value of `dur_o`. A new accepted start clears `dur_valid_o`.
- R7: While `veto_n_i` is low, the shutter is closed, `clear_o` is held high and no start is accepted. After veto is released, the controller returns to idle and accepts a new start.
- R8: A one-cycle `abort_i` pulse closes or disarms any acquisition and raises `clear_o` for exactly one cycle. The controller then returns to idle, where trigger edges are ignored.
- R9: `trig_out_n_o` is low exactly in the cycles in which the shutter is high.
- R10: `busy_o` is low only while armed for a starting edge, or while the shutter is open in a trigger-stopped mode. It is high in every other state, including idle and clear.
- R11: A start command is ignored unless the controller is idle. In modes with bit 1 clear, a start with `acq_time_i` equal to zero is also ignored.
- R12: After reset, the shutter is low, `trig_out_n_o` is high, `busy_o` is high, `clear_o` is low, and `dur_o` and `dur_valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command pulse from the host |
| mode_i | input | 2 | Start/stop mode, sampled with the start |
| acq_time_i | input | TIME_W | Exposure length in clock cycles for timer-stopped modes |
| trig_i | input | 1 | Asynchronous external trigger, falling edge active |
| veto_n_i | input | 1 | Asynchronous veto, active low |
| abort_i | input | 1 | Synchronous abort and clear pulse |
| shutter_o | output | 1 | Exposure window |
| trig_out_n_o | output | 1 | Active-low shutter mirror |
| busy_o | output | 1 | High when a trigger edge would not be accepted |
| clear_o | output | 1 | Matrix clear request |
| dur_o | output | TIME_W | Last measured exposure length in clock cycles |
| dur_valid_o | output | 1 | `dur_o` holds the length of the latest window |

## Verification
If the cycle counter is corrupted, the timer-mode window has the wrong length, and the bench counts the shutter cycles directly. A corrupted counter also gives a `dur_o` that disagrees with the bench's own count. Both show up within the same exposure. A stuck or wrongly decoded state shows up within a few cycles, as a shutter that opens without an edge, a mode-3 window that closes on its opening edge, or a `busy_o` that disagrees with the armed or open condition. A broken veto or abort path leaves `clear_o` low, or the shutter high, within three clocks of the request.

// File: rtl/shutter_ctrl.sv
module shutter_ctrl #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [TIME_W-1:0] acq_time_i,
  input  logic              trig_i,
  input  logic              veto_n_i,
  input  logic              abort_i,
  output logic              shutter_o,
  output logic              trig_out_n_o,
  output logic              busy_o,
  output logic              clear_o,
  output logic [TIME_W-1:0] dur_o,
  output logic              dur_valid_o
);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_OPEN, S_CLR} st_t;
  localparam logic [TIME_W-1:0] CNT_MAX = '1;

  st_t              state;
  logic [1:0]       mode_r;
  logic [TIME_W-1:0] acq_r, cnt;
  logic [2:0]       trig_q;
  logic [1:0]       veto_q;

  wire trig_fall = trig_q[2] & ~trig_q[1];
  wire veto_low  = ~veto_q[1];
  wire timer_ok  = mode_i[1] | (acq_time_i != '0);
  wire [TIME_W-1:0] cnt_sat = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= '1;
      veto_q <= '1;
    end else begin
      trig_q <= {trig_q[1:0], trig_i};
      veto_q <= {veto_q[0], veto_n_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      mode_r      <= '0;
      acq_r       <= '0;
      cnt         <= '0;
      dur_o       <= '0;
      dur_valid_o <= 1'b0;
    end else if (veto_low || abort_i) begin
      state <= S_CLR;
    end else begin
      case (state)
        S_IDLE: if (start_i && timer_ok) begin
          mode_r      <= mode_i;
          acq_r       <= acq_time_i;
          cnt         <= '0;
          dur_valid_o <= 1'b0;
          state       <= mode_i[0] ? S_ARM : S_OPEN;
        end
        S_ARM: if (trig_fall) begin
          cnt   <= '0;
          state <= S_OPEN;
        end
        S_OPEN: begin
          if (mode_r[1]) begin
            if (trig_fall) begin
              dur_o       <= cnt_sat;
              dur_valid_o <= 1'b1;
              state       <= S_IDLE;
            end else begin
              cnt <= cnt_sat;
            end
          end else if (cnt == acq_r - 1'b1) begin
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign shutter_o    = (state == S_OPEN);
  assign trig_out_n_o = ~shutter_o;
  assign clear_o      = (state == S_CLR);
  assign busy_o       = !((state == S_ARM) || (state == S_OPEN && mode_r[1]));

  // R3
  timer_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OPEN && !mode_r[1]) |-> (cnt < acq_r));

  // R5
  no_same_edge_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OPEN && $past(state) == S_ARM) |-> !trig_fall);

  // R6
  dur_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dur_valid_o) |-> $fell(shutter_o));

  // R7
  veto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    veto_low |=> (clear_o && !shutter_o));

  // R10
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |-> busy_o);

  // R11
  start_in_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutter_o && !veto_low && !abort_i && !trig_fall && !mode_r[1] && cnt != acq_r - 1'b1)
      |=> (shutter_o && $stable(mode_r)));

endmodule

// File: tb/test_shutter_ctrl.sv
module test_shutter_ctrl;
  localparam int TW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, trig = 1'b1, veto_n = 1'b1, abort_p = 1'b0;
  logic [1:0] mode = '0;
  logic [TW-1:0] acq = '0;
  logic shutter, trig_out_n, busy, clear;
  logic [TW-1:0] dur;
  logic dur_valid;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  shutter_ctrl #(.TIME_W(TW)) i_shutter_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .acq_time_i(acq),
    .trig_i(trig), .veto_n_i(veto_n), .abort_i(abort_p), .shutter_o(shutter),
    .trig_out_n_o(trig_out_n), .busy_o(busy), .clear_o(clear),
    .dur_o(dur), .dur_valid_o(dur_valid));

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(logic [1:0] m, int t);
    mode = m; acq = TW'(t); start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic count_open(output int n, output int mism);
    n = 0; mism = 0;
    while (shutter && n < 1000) begin
      n++;
      if (trig_out_n !== 1'b0) mism++;
      tick();
    end
    if (trig_out_n !== 1'b1) mism++;
  endtask

  task automatic t_reset;
    check(shutter == 0 && trig_out_n == 1 && busy == 1 && clear == 0 && dur == 0 && dur_valid == 0,
          "R12 reset", {shutter, trig_out_n, busy, clear, dur_valid}, 5'b01100);
  endtask

  task automatic t_timer;
    int n, m;
    do_start(2'd0, 5);
    check(shutter == 1, "R1 immediate open", shutter, 1);
    count_open(n, m);
    check(n == 5, "R3 timer length 5", n, 5);
    check(m == 0, "R9 trig_out mirror", m, 0);
    do_start(2'd0, 1);
    count_open(n, m);
    check(n == 1, "R3 timer length 1", n, 1);
    do_start(2'd0, 0);
    tick(3);
    check(shutter == 0, "R11 zero time ignored", shutter, 0);
  endtask

  task automatic t_trig_timer;
    int n, m, w;
    trig = 1'b0; tick(4);
    do_start(2'd1, 4);
    tick(2);
    check(shutter == 0 && busy == 0, "R10 armed busy low", {shutter, busy}, 0);
    trig = 1'b1; tick(5);
    check(shutter == 0, "R2 rising ignored", shutter, 0);
    trig = 1'b0;
    w = 0;
    while (!shutter && w < 10) begin w++; tick(); end
    check(shutter == 1 && busy == 1, "R1 trigger start, R10 busy in timer window", {shutter, busy}, 3);
    count_open(n, m);
    check(n == 4, "R3 trigger-started timer length", n, 4);
    trig = 1'b1; tick(3);
  endtask

  task automatic t_imm_trig;
    int n = 0;
    do_start(2'd2, 0);
    check(shutter == 1 && busy == 0, "R4 immediate open busy low", {shutter, busy}, 2);
    for (int i = 0; i < 40 && shutter; i++) begin
      n++;
      if (i == 6) trig = 1'b0;
      tick();
    end
    check(shutter == 0, "R4 closed by edge", shutter, 0);
    check(dur == TW'(n) && dur_valid == 1, "R6 duration", dur, n);
    trig = 1'b1; tick(3);
    do_start(2'd0, 2);
    check(dur_valid == 0, "R6 valid cleared on start", dur_valid, 0);
    tick(4);
  endtask

  task automatic t_both_trig;
    int n = 0, w = 0;
    do_start(2'd3, 0);
    trig = 1'b0;
    while (!shutter && w < 10) begin w++; tick(); end
    for (int i = 0; i < 4; i++) begin n += shutter; tick(); end
    trig = 1'b1;
    for (int i = 0; i < 8; i++) begin n += shutter; tick(); end
    check(shutter == 1, "R5 opening edge does not close", shutter, 1);
    trig = 1'b0;
    while (shutter && n < 100) begin n++; tick(); end
    check(dur == TW'(n) && dur_valid == 1, "R5 R6 second edge closes", dur, n);
    trig = 1'b1; tick(3);
  endtask

  task automatic t_saturate;
    do_start(2'd2, 0);
    tick(300);
    trig = 1'b0; tick(4);
    check(shutter == 0 && dur == 8'hFF, "R6 saturation", dur, 255);
    trig = 1'b1; tick(3);
  endtask

  task automatic t_veto;
    int n, m;
    do_start(2'd2, 0);
    veto_n = 1'b0; tick(3);
    check(shutter == 0 && clear == 1 && busy == 1, "R7 veto aborts", {shutter, clear, busy}, 3);
    do_start(2'd0, 3);
    tick(4);
    check(clear == 1 && shutter == 0, "R7 clear held, start ignored", {clear, shutter}, 2);
    veto_n = 1'b1; tick(4);
    check(clear == 0 && busy == 1, "R7 back to idle", {clear, busy}, 1);
    do_start(2'd0, 3);
    count_open(n, m);
    check(n == 3, "R7 restart after veto", n, 3);
  endtask

  task automatic t_abort;
    do_start(2'd1, 4);
    tick(2);
    abort_p = 1'b1; tick(); abort_p = 1'b0;
    check(clear == 1, "R8 clear pulse", clear, 1);
    tick();
    check(clear == 0 && busy == 1, "R8 one cycle then idle", {clear, busy}, 1);
    trig = 1'b0; tick(5);
    check(shutter == 0, "R8 idle ignores trigger", shutter, 0);
    trig = 1'b1; tick(3);
  endtask

  task automatic t_busy_start;
    int n = 0;
    do_start(2'd0, 10);
    for (int i = 0; i < 30 && shutter; i++) begin
      n++;
      if (i == 3) begin mode = 2'd2; start = 1'b1; end
      else start = 1'b0;
      tick();
    end
    start = 1'b0;
    check(n == 10, "R11 start ignored while open", n, 10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R12 watchdog actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(4);
    t_timer();
    t_trig_timer();
    t_imm_trig();
    t_both_trig();
    t_saturate();
    t_veto();
    t_abort();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule